// File: doc/BRIEF.md
# Derandomizing Bit Buffer with Multi-Link Byte Serializer

This block sits between a packet builder and a group of byte-wide serial link drivers. At each bunch crossing the builder may hand over one packet whose length is any number of bits, not a multiple of eight. The block keeps these packets in a circular bit-addressed store, so variable arrival sizes are smoothed out. At every crossing it also takes a fixed slice of bits from the head of the store, eight per active link, and sends that slice to the link outputs as one byte per link.

Three rules decide what goes into the store. First, when the stored data are too few to fill the current output slice, whole 16-bit filler packets are appended behind the data until the slice can be filled; filler bits the slice does not use stay queued. Second, an incoming packet is stored only if it fits whole into the space left after this crossing's drain. Third, when a packet does not fit, a 16-bit overflow packet carrying the packet's leading tag is stored in its place if there is room for it, and a saturating counter records the event. The number of active links may change from one crossing to the next.

Top module: `derand_link_serializer`

## Requirements
- R1: While `rst_n` is low at a clock edge, every link byte, `out_strobe` and `ovf_count` read zero after that edge and the store is emptied, so the first crossing after reset carries only filler bits.
- R2: On a crossing with n active links, the output slice holds 8*n bits. Link k carries slice bits 8k to 8k+7, where slice bit 8k is the earliest of them and sits at `link_data[8k+7]`. The bytes of inactive links read zero.
- R3: The active link count is taken from `link_cnt` at each crossing. A value of 0 counts as one link, and any value above `N_LINKS_MAX` counts as `N_LINKS_MAX`.
- R4: Stored bits leave in exactly the order they entered, across packet boundaries and store wrap-around. Packet bits are taken from `pkt_data` starting at bit `PKT_W-1` and working downward for `pkt_len` bits.
- R5: When fewer bits are stored than the slice needs, 16-bit filler packets of value 16'hFCFF (MSB first) are appended behind the stored bits, as few as will fill the slice. The leftover filler bits stay at the head of the store, ahead of any later packet.
- R6: Within one crossing the drain comes first. A packet that arrives with the crossing never appears in that crossing's slice, and the space freed by that drain is available to it.
- R7: A packet is stored whole when `pkt_len` is no greater than the free space left after this crossing's drain and filler. A packet that fills that space exactly is accepted.
- R8: A packet that does not fit is never stored, not even in part. If the free space is at least 16 bits, the 16-bit overflow packet {pkt_data[PKT_W-1:PKT_W-4], 12'hAFF} is stored in its place. Otherwise nothing is stored.
- R9: `ovf_count` increases by one for each rejected packet, does not change at any other time, and holds at its all-ones value.
- R10: `pkt_valid` is ignored when `xing` is low. A packet with `pkt_len` of 0 stores nothing and is not counted.
- R11: `out_strobe` is high for exactly the one clock that follows each crossing. The link bytes change only at a crossing and hold their value between crossings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one crossing takes one cycle in which `xing` is high |
| rst_n | input | 1 | Synchronous active-low reset |
| xing | input | 1 | Bunch-crossing strobe: drain a slice and optionally accept a packet |
| link_cnt | input | 3 | Requested number of active links |
| pkt_valid | input | 1 | A packet is presented with this crossing |
| pkt_len | input | 8 | Packet length in bits, at most `PKT_W` |
| pkt_data | input | PKT_W | Packet bits, first bit at the MSB |
| link_data | output | 8*N_LINKS_MAX | One byte per link, link k at bits 8k+7..8k, MSB sent first |
| out_strobe | output | 1 | New link bytes are present |
| ovf_count | output | CNT_W | Saturating count of rejected packets |

## Verification
The bench builds the block with a 512-bit store, five links, 64-bit packets and a 4-bit event counter. The small store can be filled within about ten crossings from a single link, so the bench can reach the exact-fit boundary, the case where free space is below 16 bits (packet dropped) and the case where the overflow packet is stored. The 4-bit counter lets the bench reach saturation. Five links also make every clamp value of `link_cnt` reachable, and the 64-bit packet width lets random lengths cover every bit alignment against the byte slots.

// File: rtl/drlb_pkg.sv
// Package drlb_pkg
// Shared constants and helpers for the derandomizing link serializer.
// Assumes the link count request is 3 bits wide (at most 7 links).
package drlb_pkg;

    localparam int          FILLER_BITS = 16;
    localparam logic [15:0] FILLER_WORD = 16'hFCFF;
    localparam logic [11:0] OVF_TAIL    = 12'hAFF;

    // Map a requested link count onto the range 1..max_links
    function automatic int clamp_links(input logic [2:0] req, input int max_links);
        int n;
        n = int'(req);
        if (n < 1)         n = 1;
        if (n > max_links) n = max_links;
        return n;
    endfunction

endpackage

// File: rtl/drlb_admit.sv
// Module drlb_admit
// Combinational admission control for one crossing. It works out the slot
// size from the link request, the filler bits needed to cover the slot, and
// whether the incoming packet is stored, replaced by an overflow packet or
// dropped. Assumes the store occupancy is at most BUF_BITS and PKT_W > 16.
module drlb_admit
    import drlb_pkg::*;
#(
    parameter int BUF_BITS    = 4096,
    parameter int N_LINKS_MAX = 5,
    parameter int PKT_W       = 64,
    parameter int OW          = 13
) (
    input  logic             xing,
    input  logic [OW-1:0]    occ,
    input  logic [2:0]       link_cnt,
    input  logic             pkt_valid,
    input  logic [7:0]       pkt_len,
    input  logic [PKT_W-1:0] pkt_data,
    output logic [2:0]       n_act,
    output logic [OW-1:0]    slot_len,
    output logic [OW-1:0]    fill_len,
    output logic [OW-1:0]    wr_len,
    output logic [PKT_W-1:0] wr_word,
    output logic             reject
);

    // Decide slot, filler and write content for this crossing
    always_comb begin
        int n;
        int slot;
        int fill;
        int occ_i;
        int after;
        int free_bits;
        int len;
        n         = clamp_links(link_cnt, N_LINKS_MAX);
        slot      = 8 * n;
        occ_i     = int'(occ);
        fill      = 0;
        if (occ_i < slot) begin
            fill = ((slot - occ_i + FILLER_BITS - 1) / FILLER_BITS) * FILLER_BITS;
        end
        after     = occ_i + fill - slot;
        free_bits = BUF_BITS - after;
        len       = int'(pkt_len);
        wr_len    = '0;
        wr_word   = '0;
        reject    = 1'b0;
        if (xing && pkt_valid && (len != 0)) begin
            if (len <= free_bits) begin
                wr_len  = OW'(len);
                wr_word = pkt_data;
            end else begin
                reject = 1'b1;
                if (free_bits >= FILLER_BITS) begin
                    wr_len  = OW'(FILLER_BITS);
                    wr_word = {pkt_data[PKT_W-1 -: 4], OVF_TAIL, {(PKT_W-16){1'b0}}};
                end
            end
        end
        n_act    = 3'(n);
        slot_len = OW'(slot);
        fill_len = OW'(fill);
    end

endmodule

// File: rtl/drlb_bitstore.sv
// Module drlb_bitstore
// Circular bit store with bit-granular read and write pointers. On a
// crossing it shows the head slot (bits past the stored data read as the
// filler pattern being appended in the same crossing), then writes filler
// and packet bits at the tail. Assumes BUF_BITS is a power of two and at
// least SLOT_MAX + FILL_MAX + PKT_W.
module drlb_bitstore
    import drlb_pkg::*;
#(
    parameter int BUF_BITS = 4096,
    parameter int PKT_W    = 64,
    parameter int SLOT_MAX = 40,
    parameter int AW       = 12,
    parameter int OW       = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xing,
    input  logic [OW-1:0]       fill_len,
    input  logic [OW-1:0]       wr_len,
    input  logic [PKT_W-1:0]    wr_word,
    input  logic [OW-1:0]       slot_len,
    output logic [SLOT_MAX-1:0] slot_bits,
    output logic [OW-1:0]       occ
);

    localparam int FILL_MAX = ((SLOT_MAX + FILLER_BITS - 1) / FILLER_BITS) * FILLER_BITS;
    localparam int STG_W    = FILL_MAX + PKT_W;

    logic [BUF_BITS-1:0] mem;
    logic [AW-1:0]       rd_ptr;
    logic [AW-1:0]       wr_ptr;
    logic [OW-1:0]       occ_q;
    logic [STG_W-1:0]    stg_bit;
    logic [STG_W-1:0]    stg_en;
    logic [AW-1:0]       stg_idx [STG_W];
    logic [AW-1:0]       rd_idx  [SLOT_MAX];

    assign occ = occ_q;

    // Build the tail write stage: filler bits first, then the packet bits
    always_comb begin
        int fl;
        int j;
        fl = int'(fill_len);
        for (int i = 0; i < STG_W; i++) begin
            stg_idx[i] = wr_ptr + AW'(i);
            stg_en[i]  = 1'b0;
            stg_bit[i] = 1'b0;
            j          = i - fl;
            if (i < fl) begin
                stg_en[i]  = 1'b1;
                stg_bit[i] = FILLER_WORD[15 - (i % FILLER_BITS)];
            end else if ((j < int'(wr_len)) && (j < PKT_W)) begin
                stg_en[i]  = 1'b1;
                stg_bit[i] = wr_word[PKT_W - 1 - j];
            end
        end
    end

    // Present the head slot, blending in filler past the stored bits
    always_comb begin
        int oc;
        oc = int'(occ_q);
        for (int i = 0; i < SLOT_MAX; i++) begin
            rd_idx[i] = rd_ptr + AW'(i);
            if (i < oc) begin
                slot_bits[SLOT_MAX-1-i] = mem[rd_idx[i]];
            end else begin
                slot_bits[SLOT_MAX-1-i] = FILLER_WORD[15 - ((i - oc) % FILLER_BITS)];
            end
        end
    end

    // Store the staged bits at the tail on a crossing
    always_ff @(posedge clk) begin
        if (xing) begin
            for (int i = 0; i < STG_W; i++) begin
                if (stg_en[i]) begin
                    mem[stg_idx[i]] <= stg_bit[i];
                end
            end
        end
    end

    // Advance the pointers and the occupancy on a crossing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            occ_q  <= '0;
        end else if (xing) begin
            rd_ptr <= rd_ptr + AW'(slot_len);
            wr_ptr <= wr_ptr + AW'(fill_len + wr_len);
            occ_q  <= occ_q + fill_len + wr_len - slot_len;
        end
    end

endmodule

// File: rtl/drlb_link_pack.sv
// Module drlb_link_pack
// Splits the head slot into one byte per link, in link order, and holds the
// bytes between crossings. Bytes of inactive links are forced to zero.
module drlb_link_pack #(
    parameter int N_LINKS_MAX = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     xing,
    input  logic [2:0]               n_act,
    input  logic [8*N_LINKS_MAX-1:0] slot_bits,
    output logic [8*N_LINKS_MAX-1:0] link_data,
    output logic                     out_strobe
);

    localparam int SLOT_MAX = 8 * N_LINKS_MAX;

    for (genvar k = 0; k < N_LINKS_MAX; k++) begin : g_lane
        // Register the byte for link k on a crossing
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                link_data[8*k +: 8] <= '0;
            end else if (xing) begin
                link_data[8*k +: 8] <= (n_act > 3'(k)) ? slot_bits[SLOT_MAX-1-8*k -: 8] : 8'h00;
            end
        end
    end

    // Flag the cycle after each crossing
    always_ff @(posedge clk) begin
        if (!rst_n) out_strobe <= 1'b0;
        else        out_strobe <= xing;
    end

endmodule

// File: rtl/derand_link_serializer.sv
// Module derand_link_serializer
// Derandomizing bit buffer feeding up to N_LINKS_MAX byte links. At each
// crossing (xing high) it drains 8 bits per active link, pads with filler
// packets when the store runs short, and admits, replaces or drops the
// incoming packet. Assumes BUF_BITS is a power of two, N_LINKS_MAX <= 7,
// 16 < PKT_W <= 255.
module derand_link_serializer #(
    parameter int BUF_BITS    = 4096,
    parameter int N_LINKS_MAX = 5,
    parameter int PKT_W       = 64,
    parameter int CNT_W       = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     xing,
    input  logic [2:0]               link_cnt,
    input  logic                     pkt_valid,
    input  logic [7:0]               pkt_len,
    input  logic [PKT_W-1:0]         pkt_data,
    output logic [8*N_LINKS_MAX-1:0] link_data,
    output logic                     out_strobe,
    output logic [CNT_W-1:0]         ovf_count
);

    localparam int AW       = $clog2(BUF_BITS);
    localparam int OW       = AW + 1;
    localparam int SLOT_MAX = 8 * N_LINKS_MAX;

    logic [OW-1:0]       occ;
    logic [2:0]          n_act;
    logic [OW-1:0]       slot_len;
    logic [OW-1:0]       fill_len;
    logic [OW-1:0]       wr_len;
    logic [PKT_W-1:0]    wr_word;
    logic                reject;
    logic [SLOT_MAX-1:0] slot_bits;

    drlb_admit #(
        .BUF_BITS   (BUF_BITS),
        .N_LINKS_MAX(N_LINKS_MAX),
        .PKT_W      (PKT_W),
        .OW         (OW)
    ) u_admit (
        .xing     (xing),
        .occ      (occ),
        .link_cnt (link_cnt),
        .pkt_valid(pkt_valid),
        .pkt_len  (pkt_len),
        .pkt_data (pkt_data),
        .n_act    (n_act),
        .slot_len (slot_len),
        .fill_len (fill_len),
        .wr_len   (wr_len),
        .wr_word  (wr_word),
        .reject   (reject)
    );

    drlb_bitstore #(
        .BUF_BITS(BUF_BITS),
        .PKT_W   (PKT_W),
        .SLOT_MAX(SLOT_MAX),
        .AW      (AW),
        .OW      (OW)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .xing     (xing),
        .fill_len (fill_len),
        .wr_len   (wr_len),
        .wr_word  (wr_word),
        .slot_len (slot_len),
        .slot_bits(slot_bits),
        .occ      (occ)
    );

    drlb_link_pack #(
        .N_LINKS_MAX(N_LINKS_MAX)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .xing      (xing),
        .n_act     (n_act),
        .slot_bits (slot_bits),
        .link_data (link_data),
        .out_strobe(out_strobe)
    );

    // Count rejected packets, holding at all ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_count <= '0;
        end else if (reject && (ovf_count != {CNT_W{1'b1}})) begin
            ovf_count <= ovf_count + 1'b1;
        end
    end

endmodule

// File: rtl/derand_link_serializer_chk.sv
// Module derand_link_serializer_chk
// Temporal checks on the serializer's ports and store occupancy; attached
// to every instance of the top module by the bind below.
module derand_link_serializer_chk #(
    parameter int BUF_BITS    = 4096,
    parameter int N_LINKS_MAX = 5,
    parameter int CNT_W       = 16,
    parameter int OW          = 13
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     xing,
    input logic [2:0]               link_cnt,
    input logic [8*N_LINKS_MAX-1:0] link_data,
    input logic                     out_strobe,
    input logic [CNT_W-1:0]         ovf_count,
    input logic [OW-1:0]            occ
);

    a_r11_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        xing |=> out_strobe);

    a_r11_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
        !xing |=> !out_strobe);

    a_r11_bytes_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !xing |=> $stable(link_data));

    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ovf_count == $past(ovf_count)) || (ovf_count == $past(ovf_count) + 1'b1)));

    a_r9_count_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !xing |=> $stable(ovf_count));

    a_r3_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (out_strobe && ($past(link_cnt) <= 3'd1)) |-> (link_data[8*N_LINKS_MAX-1:8] == '0));

    a_r7_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= BUF_BITS);

endmodule

bind derand_link_serializer derand_link_serializer_chk #(
    .BUF_BITS   (BUF_BITS),
    .N_LINKS_MAX(N_LINKS_MAX),
    .CNT_W      (CNT_W),
    .OW         (OW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xing      (xing),
    .link_cnt  (link_cnt),
    .link_data (link_data),
    .out_strobe(out_strobe),
    .ovf_count (ovf_count),
    .occ       (occ)
);

// File: tb/derand_link_serializer_tb.sv
module derand_link_serializer_tb;

    localparam int BUF     = 512;
    localparam int NL      = 5;
    localparam int PW      = 64;
    localparam int CW      = 4;
    localparam int CNT_MAX = (1 << CW) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              xing = 1'b0;
    logic [2:0]        link_cnt = 3'd1;
    logic              pkt_valid = 1'b0;
    logic [7:0]        pkt_len = 8'd0;
    logic [PW-1:0]     pkt_data = '0;
    logic [8*NL-1:0]   link_data;
    logic              out_strobe;
    logic [CW-1:0]     ovf_count;

    int                total = 0;
    int                bad = 0;
    bit                done = 1'b0;
    string             tag = "R1";

    bit                q[$];
    logic [8*NL-1:0]   exp_link = '0;
    logic              exp_strobe = 1'b0;
    int                exp_cnt = 0;

    always #2.5 clk = ~clk;

    derand_link_serializer #(
        .BUF_BITS(BUF), .N_LINKS_MAX(NL), .PKT_W(PW), .CNT_W(CW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .xing(xing), .link_cnt(link_cnt),
        .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_data(pkt_data),
        .link_data(link_data), .out_strobe(out_strobe), .ovf_count(ovf_count)
    );

    task automatic chk(input string t, input longint act, input longint expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", t, act, expv, $time);
        end
    endtask

    task automatic compare_all();
        chk(tag, longint'(link_data), longint'(exp_link));
        chk("R11", longint'(out_strobe), longint'(exp_strobe));
        chk("R9", longint'(ovf_count), longint'(exp_cnt));
    endtask

    // Behavioural reference: a bit queue updated once per crossing
    task automatic model(input logic x, input int lc, input logic v, input int len,
                         input logic [PW-1:0] d);
        int n;
        int freeb;
        logic [15:0] ov;
        if (!rst_n) begin
            q.delete();
            exp_link = '0;
            exp_strobe = 1'b0;
            exp_cnt = 0;
            return;
        end
        exp_strobe = x;
        if (!x) return;
        n = (lc < 1) ? 1 : ((lc > NL) ? NL : lc);
        while (q.size() < 8 * n)
            for (int j = 0; j < 16; j++) q.push_back(16'hFCFF >> (15 - j));
        exp_link = '0;
        for (int b = 0; b < n; b++)
            for (int j = 0; j < 8; j++) exp_link[8*b + 7 - j] = q.pop_front();
        if (v && len != 0) begin
            freeb = BUF - q.size();
            if (len <= freeb) begin
                for (int j = 0; j < len; j++) q.push_back(d[PW-1-j]);
            end else begin
                if (freeb >= 16) begin
                    ov = {d[PW-1 -: 4], 12'hAFF};
                    for (int j = 0; j < 16; j++) q.push_back(ov[15-j]);
                end
                if (exp_cnt < CNT_MAX) exp_cnt++;
            end
        end
    endtask

    task automatic step(input logic x, input int lc, input logic v, input int len,
                        input logic [PW-1:0] d);
        @(negedge clk);
        compare_all();
        xing = x; link_cnt = 3'(lc); pkt_valid = v; pkt_len = 8'(len); pkt_data = d;
        model(x, lc, v, len, d);
    endtask

    task automatic crossing(input int lc, input logic v, input int len, input logic [PW-1:0] d);
        step(1'b1, lc, v, len, d);
        repeat (4) step(1'b0, lc, 1'b0, 0, '0);
    endtask

    function automatic logic [PW-1:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        int fa;
        int c0;
        // R1: reset state
        tag = "R1";
        repeat (3) step(1'b0, 1, 1'b0, 0, '0);
        chk("R1", longint'(link_data), 0);
        chk("R1", longint'(ovf_count), 0);
        rst_n = 1'b1;
        // R1/R5: first crossing shows only filler
        crossing(2, 1'b0, 0, '0);
        chk("R5", longint'(link_data[15:0]), longint'(16'hFFFC));
        // R2/R3: every link request value, idle store
        tag = "R3";
        for (int lc = 0; lc < 8; lc++) crossing(lc, 1'b0, 0, '0);
        tag = "R2";
        for (int lc = 5; lc > 0; lc--) crossing(lc, 1'b0, 0, '0);
        // R4/R6: random unaligned packets, moderate load
        tag = "R4";
        for (int i = 0; i < 40; i++) crossing(3, 1'b1, int'($urandom_range(1, 64)), rnd64());
        tag = "R6";
        for (int i = 0; i < 20; i++) crossing(1 + (i % 5), 1'b1, int'($urandom_range(1, 40)), rnd64());
        // R10: packets outside a crossing and zero-length packets
        tag = "R10";
        c0 = exp_cnt;
        for (int i = 0; i < 10; i++) begin
            step(1'b1, 4, 1'b1, 0, rnd64());
            repeat (4) step(1'b0, 4, 1'b1, 40, rnd64());
        end
        chk("R10", longint'(ovf_count), longint'(c0));
        for (int i = 0; i < 6; i++) crossing(5, 1'b0, 0, '0);
        // R7: fill the store from one link, then fit a packet exactly
        tag = "R7";
        for (int i = 0; i < 20; i++) crossing(5, 1'b0, 0, '0);
        while (q.size() < BUF - 100) crossing(1, 1'b1, 64, rnd64());
        fa = BUF - (q.size() - 8);
        while (fa > 64) begin
            crossing(1, 1'b1, 64, rnd64());
            fa = BUF - (q.size() - 8);
        end
        c0 = exp_cnt;
        crossing(1, 1'b1, fa, rnd64());
        chk("R7", longint'(ovf_count), longint'(c0));
        // R8: free space 8 bits, packet dropped without trace
        tag = "R8";
        crossing(1, 1'b1, 64, rnd64());
        chk("R8", longint'(ovf_count), longint'(c0 + 1));
        // R8: free space 32 bits, overflow packet stored
        crossing(3, 1'b1, 64, {4'h9, 60'h0});
        chk("R8", longint'(ovf_count), longint'(c0 + 2));
        for (int i = 0; i < 20; i++) crossing(5, 1'b0, 0, '0);
        // R9: count saturation under sustained rejection
        tag = "R9";
        for (int i = 0; i < 40; i++) crossing(1, 1'b1, 64, rnd64());
        chk("R9", longint'(ovf_count), longint'(CNT_MAX));
        for (int i = 0; i < 20; i++) crossing(5, 1'b0, 0, '0);
        @(negedge clk);
        compare_all();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule